// File: doc/BRIEF.md
# Ping-Pong Playback DMA Sequencer

This block drives the read side of an audio playback stream that alternates between two memory regions. A host programs a start address and a byte length for each region, chooses a sample format, and sets a run bit. Each pulse on the frame-request input then asks the memory master for one frame at the current address and moves the offset on by the frame size. When a region is used up, the block raises that region's finished flag and continues at offset zero of the other region. The host refills the region just drained while the other one plays.

The host sees sixteen-bit registers at even byte offsets. Thirty-two-bit values are split into a low half and a high half two bytes above it. The finished flags are cleared by writing ones. A level interrupt output and a mirrored pending output stay high while any flag is set.

Top module: `pcm_pingpong_dma`

## Requirements
- R1: After reset, every register reads zero except the format register at 0x16, which reads 0x0010. `irq` and `play_pending` are low.
- R2: Counting and fetching happen only while bit 0 of the control register (0x00) is 1. While it is 0, frame requests produce no `fetch_req`, and the offset and active region are held.
- R3: Region 1 start is at 0x04 (low) and 0x06 (high), and region 2 start is at 0x08 and 0x0A. The 16-bit lengths are at 0x0C (region 1) and 0x0E (region 2). The position at 0x10/0x12 and `fetch_addr` both equal the active region's start plus the offset at 0x14.
- R4: Only bits 5:0 of the control and format registers can be written. Bits 15:6 of those registers read as zero. In the interrupt register at 0x02, only bits 2:1 can read as one.
- R5: Bit 1 of 0x02 is set when region 1 is exhausted, and bit 2 when region 2 is exhausted. A flag stays set until a 1 is written to its bit. Writing 0 has no effect, and writing 0xFFFF clears both flags.
- R6: If a finish and an acknowledge of the same flag fall in one cycle, the flag remains set. Flags acknowledged in that write but not being set are cleared.
- R7: Format bit 4 selects 16-bit samples and bit 5 selects stereo. The bytes per frame are 1 (neither bit), 2 (one of them) or 4 (both). Each accepted frame request pulses `fetch_req` with `fetch_addr` at the position before the advance, then adds the bytes per frame to the offset.
- R8: When the advanced offset reaches or passes the active length, the region's flag is set, the other region becomes active, and the offset returns to zero.
- R9: `irq` and `play_pending` are high exactly while at least one finished flag is set.
- R10: While running, an active region of length zero is flagged and skipped within one cycle, with no fetch issued for it.
- R11: Clearing and then setting the run bit continues from the held offset, not from the region start.
- R12: Writes to the position (0x10, 0x12) and offset (0x14) registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset of the register being accessed |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| frame_req | input | 1 | One-cycle request for the next frame |
| fetch_req | output | 1 | Fetch request to the memory master |
| fetch_addr | output | 32 | Current absolute byte address |
| irq | output | 1 | Interrupt, high while any finished flag is set |
| play_pending | output | 1 | Playback status, mirrors `irq` |

## Verification
A hardware finish and a host acknowledge can land on the same edge. The bench arranges this by sending the frame that drains region 1 in the same cycle as a write of 0x0006 to the interrupt register. That write acknowledges the older region 2 flag and also tries to clear the region 1 flag that is being raised. The readback must be 0x0002: the new flag survives and the old one is gone. A scoreboard checks every fetch address against a model of the two regions and the frame size, which the bench computes from the requirements.

// File: rtl/pcm_pingpong_dma.sv
module pcm_pingpong_dma #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        frame_req,
  output logic        fetch_req,
  output logic [31:0] fetch_addr,
  output logic        irq,
  output logic        play_pending
);
  localparam logic [4:0] A_CTRL = 5'h00, A_IRQ = 5'h02, A_S1L = 5'h04, A_S1H = 5'h06,
                         A_S2L = 5'h08, A_S2H = 5'h0A, A_L1 = 5'h0C, A_L2 = 5'h0E,
                         A_POSL = 5'h10, A_POSH = 5'h12, A_OFS = 5'h14, A_FMT = 5'h16;
  localparam int SUM_W = LEN_W + 1;

  logic [5:0]        ctrl_q, fmt_q;
  logic [1:0]        done_q;
  logic [ADDR_W-1:0] st1_q, st2_q;
  logic [LEN_W-1:0]  len1_q, len2_q, ofs_q;
  logic              sel_q;

  logic              run, empty, wrap, skip;
  logic [2:0]        bpf;
  logic [LEN_W-1:0]  len_act;
  logic [SUM_W-1:0]  sum;
  logic [1:0]        set_v, ack_v;
  logic [ADDR_W-1:0] pos;
  logic [31:0]       pos32, st1_32, st2_32;

  assign run     = ctrl_q[0];
  assign bpf     = (fmt_q[4] & fmt_q[5]) ? 3'd4 : (fmt_q[4] | fmt_q[5]) ? 3'd2 : 3'd1;
  assign len_act = sel_q ? len2_q : len1_q;
  assign empty   = (len_act == '0);
  assign sum     = {1'b0, ofs_q} + SUM_W'(bpf);
  assign fetch_req = run & frame_req & ~empty;
  assign wrap    = fetch_req & (sum >= {1'b0, len_act});
  assign skip    = run & empty;
  assign set_v   = (wrap | skip) ? (sel_q ? 2'b10 : 2'b01) : 2'b00;
  assign ack_v   = (reg_we && reg_addr == A_IRQ) ? reg_wdata[2:1] : 2'b00;

  assign pos        = (sel_q ? st2_q : st1_q) + ADDR_W'(ofs_q);
  assign pos32      = 32'(pos);
  assign st1_32     = 32'(st1_q);
  assign st2_32     = 32'(st2_q);
  assign fetch_addr = pos32;
  assign irq          = |done_q;
  assign play_pending = irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fmt_q  <= 6'h10;
      st1_q  <= '0;
      st2_q  <= '0;
      len1_q <= '0;
      len2_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: ctrl_q <= reg_wdata[5:0];
        A_FMT:  fmt_q  <= reg_wdata[5:0];
        A_S1L:  st1_q  <= ADDR_W'({st1_32[31:16], reg_wdata});
        A_S1H:  st1_q  <= ADDR_W'({reg_wdata, st1_32[15:0]});
        A_S2L:  st2_q  <= ADDR_W'({st2_32[31:16], reg_wdata});
        A_S2H:  st2_q  <= ADDR_W'({reg_wdata, st2_32[15:0]});
        A_L1:   len1_q <= LEN_W'(reg_wdata);
        A_L2:   len2_q <= LEN_W'(reg_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      sel_q  <= 1'b0;
      done_q <= '0;
    end else begin
      done_q <= (done_q & ~ack_v) | set_v;
      if (wrap | skip) begin
        ofs_q <= '0;
        sel_q <= ~sel_q;
      end else if (fetch_req) begin
        ofs_q <= sum[LEN_W-1:0];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL: reg_rdata = {10'd0, ctrl_q};
      A_IRQ:  reg_rdata = {13'd0, done_q, 1'b0};
      A_S1L:  reg_rdata = st1_32[15:0];
      A_S1H:  reg_rdata = st1_32[31:16];
      A_S2L:  reg_rdata = st2_32[15:0];
      A_S2H:  reg_rdata = st2_32[31:16];
      A_L1:   reg_rdata = 16'(len1_q);
      A_L2:   reg_rdata = 16'(len2_q);
      A_POSL: reg_rdata = pos32[15:0];
      A_POSH: reg_rdata = pos32[31:16];
      A_OFS:  reg_rdata = 16'(ofs_q);
      A_FMT:  reg_rdata = {10'd0, fmt_q};
      default: reg_rdata = 16'd0;
    endcase
  end

  p_pause_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(ofs_q) && $stable(sel_q)));
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q[0] && !ack_v[0]) |=> done_q[0]);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_v[1] |=> done_q[1]);
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !wrap) |=> (ofs_q == $past(ofs_q) + LEN_W'($past(bpf))));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ofs_q == '0 && sel_q != $past(sel_q)));
  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(run));
endmodule

// File: tb/pcm_pingpong_dma_test.sv
module pcm_pingpong_dma_test;
  logic clk = 0, rst_n = 0, reg_we = 0, frame_req = 0;
  logic [4:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic fetch_req, irq, play_pending;
  logic [31:0] fetch_addr;

  pcm_pingpong_dma uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_req(frame_req),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .irq(irq), .play_pending(play_pending));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] expq[$];

  logic [31:0] m_st[2];
  logic [15:0] m_len[2];
  logic [15:0] m_ofs = 0;
  int          m_sel = 0;
  logic [1:0]  m_flags = 0;
  logic        m_run = 0;
  int          m_bpf = 2;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic m_settle();
    if (m_run && m_len[m_sel] == 0) begin
      m_flags[m_sel] = 1'b1;
      m_sel ^= 1;
    end
  endtask

  task automatic m_step(output logic [1:0] setb);
    setb = 0;
    if (m_run && m_len[m_sel] != 0) begin
      expq.push_back(m_st[m_sel] + 32'(m_ofs));
      if (32'(m_ofs) + 32'(m_bpf) >= 32'(m_len[m_sel])) begin
        setb[m_sel] = 1'b1;
        m_sel ^= 1;
        m_ofs = 0;
      end else m_ofs = m_ofs + 16'(m_bpf);
    end
  endtask

  task automatic m_write(logic [4:0] a, logic [15:0] d);
    case (a)
      5'h00: m_run = d[0];
      5'h02: m_flags &= ~d[2:1];
      5'h04: m_st[0][15:0] = d;
      5'h06: m_st[0][31:16] = d;
      5'h08: m_st[1][15:0] = d;
      5'h0A: m_st[1][31:16] = d;
      5'h0C: m_len[0] = d;
      5'h0E: m_len[1] = d;
      5'h16: m_bpf = (d[4] ? 2 : 1) * (d[5] ? 2 : 1);
      default: ;
    endcase
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    m_write(a, d);
    @(negedge clk);
    reg_we = 0;
    m_settle();
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #2 v = reg_rdata;
  endtask

  task automatic frame();
    logic [1:0] s;
    @(negedge clk);
    m_step(s);
    m_flags |= s;
    frame_req = 1;
    @(negedge clk);
    frame_req = 0;
    m_settle();
  endtask

  task automatic wr_frame(logic [4:0] a, logic [15:0] d);
    logic [1:0] s;
    @(negedge clk);
    m_step(s);
    m_flags = (m_flags & ~d[2:1]) | s;
    reg_we = 1; reg_addr = a; reg_wdata = d; frame_req = 1;
    @(negedge clk);
    reg_we = 0; frame_req = 0;
    m_settle();
  endtask

  always begin
    @(negedge clk);
    #4;
    if (rst_n && fetch_req) begin
      if (expq.size() == 0) chk("R2/R10 unexpected fetch", fetch_addr, 32'hxxxxxxxx);
      else chk("R7 fetch address", fetch_addr, expq.pop_front());
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    m_st[0] = 0; m_st[1] = 0; m_len[0] = 0; m_len[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'h00, v); chk("R1 ctrl", 32'(v), 0);
    rd(5'h02, v); chk("R1 irq reg", 32'(v), 0);
    rd(5'h16, v); chk("R1 format", 32'(v), 32'h10);
    rd(5'h10, v); chk("R1 position", 32'(v), 0);
    rd(5'h14, v); chk("R1 offset", 32'(v), 0);
    chk("R1 irq pin", {30'd0, irq, play_pending}, 0);

    wr(5'h00, 16'hFFFE); rd(5'h00, v); chk("R4 ctrl mask", 32'(v), 32'h3E);
    wr(5'h00, 16'h0000);
    wr(5'h16, 16'hFFFF); rd(5'h16, v); chk("R4 format mask", 32'(v), 32'h3F);
    wr(5'h02, 16'hFFFF); rd(5'h02, v); chk("R4 irq mask", 32'(v), 0);

    wr(5'h04, 16'h2340); wr(5'h06, 16'h0001);
    wr(5'h08, 16'h0000); wr(5'h0A, 16'h0005);
    wr(5'h0C, 16'd8);    wr(5'h0E, 16'd6);
    wr(5'h16, 16'h0010);
    rd(5'h06, v); chk("R3 start1 hi", 32'(v), 32'h1);
    rd(5'h04, v); chk("R3 start1 lo", 32'(v), 32'h2340);
    rd(5'h0E, v); chk("R3 len2", 32'(v), 6);

    frame(); frame();
    rd(5'h14, v); chk("R2 offset held at stop", 32'(v), 0);

    wr(5'h00, 16'h0001);
    frame(); frame(); frame();
    rd(5'h14, v); chk("R7 offset after 3 frames", 32'(v), 6);
    rd(5'h10, v); chk("R3 position lo", 32'(v), 32'h2346);
    rd(5'h12, v); chk("R3 position hi", 32'(v), 32'h1);
    chk("R3 fetch_addr", fetch_addr, 32'h00012346);

    wr(5'h14, 16'hFFFF); wr(5'h10, 16'hAAAA);
    rd(5'h14, v); chk("R12 offset unwritable", 32'(v), 6);
    rd(5'h10, v); chk("R12 position unwritable", 32'(v), 32'h2346);

    wr(5'h00, 16'h0000);
    frame(); frame();
    rd(5'h14, v); chk("R2 paused offset", 32'(v), 6);
    wr(5'h00, 16'h0001);
    frame();
    rd(5'h02, v); chk("R5 region1 flag", 32'(v), 32'h2);
    chk("R9 irq high", {30'd0, irq, play_pending}, 32'h3);
    rd(5'h14, v); chk("R8 offset back to zero", 32'(v), 0);
    frame();
    rd(5'h10, v); chk("R8 region2 position", 32'(v), 32'h0002);

    wr(5'h02, 16'h0000); rd(5'h02, v); chk("R5 write zero keeps flag", 32'(v), 32'h2);
    wr(5'h02, 16'h0002); rd(5'h02, v); chk("R5 ack clears", 32'(v), 0);
    chk("R9 irq low", {30'd0, irq, play_pending}, 0);

    wr(5'h16, 16'h0030);
    frame();
    rd(5'h02, v); chk("R5 region2 flag", 32'(v), {14'd0, m_flags, 1'b0});
    frame();
    wr_frame(5'h02, 16'h0006);
    rd(5'h02, v); chk("R6 set beats ack", 32'(v), 32'h2);
    frame(); frame();
    rd(5'h02, v); chk("R5 both flags", 32'(v), 32'h6);
    wr(5'h02, 16'hFFFF); rd(5'h02, v); chk("R5 global ack", 32'(v), 0);

    wr(5'h16, 16'h0000);
    frame(); frame(); frame();
    rd(5'h14, v); chk("R7 byte steps", 32'(v), 3);
    wr(5'h16, 16'h0020);
    frame();
    rd(5'h14, v); chk("R7 stereo 8-bit step", 32'(v), 5);

    wr(5'h00, 16'h0000); wr(5'h0E, 16'h0000); wr(5'h00, 16'h0001);
    rd(5'h14, v); chk("R11 resume offset", 32'(v), 5);
    frame(); frame();
    rd(5'h02, v); chk("R10 empty region flagged", 32'(v), {14'd0, m_flags, 1'b0});
    chk("R10 both flags", {30'd0, m_flags}, 32'h3);
    frame();
    rd(5'h14, v); chk("R10 back in region1", 32'(v), 32'(m_ofs));

    repeat (4) @(negedge clk);
    chk("R7 all fetches seen", expq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule